// File: doc/BRIEF.md
# Three-Bank Level Interrupt Aggregator with Fast-Path Mirrors

The block gathers level-sensitive interrupt lines into three groups: a primary group of 8 lines and two secondary groups of 32 lines each. Each group has a status word, a mask that software sets by writing ones to one address, and a mask that software clears by writing ones to another address. The primary status word is the one software reads first. It holds the primary group's masked lines. It also holds one summary flag per secondary group and a set of mirror bits. Each mirror bit copies one chosen secondary line, so software can identify that line without reading the secondary word.

A mirrored line that is active and enabled shows in its mirror bit and in its own group's status word. It does not raise that group's summary flag. The summary flags are derived values and have no mask of their own. Mirror positions in the primary group's mask registers do not exist, so the only way to mask a mirrored line is through its own group's mask. The single interrupt output is raised when any bit of the primary status word is set. The status words follow the input lines directly and have no latch to clear.

Top module: `banked_irq_agg`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every mask bit is 0. All status words read 0 and irq_out is 0, even while input lines are high.
- R2: A write of a 1 to a mask-set address (primary 0x18, secondary A 0x10, secondary B 0x14) enables that line from the next cycle. Bits written as 0 leave the mask unchanged. Reading either the mask-set address or the mask-clear address of a group returns the current mask.
- R3: A write of a 1 to a mask-clear address (primary 0x24, secondary A 0x1C, secondary B 0x20) disables that line from the next cycle. Bits written as 0 leave the mask unchanged.
- R4: The secondary status words (A at 0x04, B at 0x08) and bits 7:0 of the primary status word (0x00) read as input AND mask, in the same cycle as the input changes.
- R5: Primary status bit 8 is 1 exactly when some enabled, active line of secondary group A is not mirrored. Bit 9 has the same meaning for group B.
- R6: Group A lines 7, 9, 10, 18, 19 appear in that order on primary status bits 10 to 14. Group B lines 21, 22, 23, 24, 25, 30 appear in that order on bits 15 to 20. Each mirror bit is the line AND its own group's mask bit.
- R7: Writes to bits 31:8 of the primary mask-set and mask-clear addresses have no effect. A primary mask read returns 0 in bits 31:8, and primary status bits 31:21 read 0.
- R8: irq_out is high exactly when any of primary status bits 0 to 20 is set, with no register on the path. It falls as soon as the causing line falls.
- R9: Any address other than the nine listed reads 0, and a write to it changes no mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| line_p | input | 8 | Primary group interrupt lines |
| line_a | input | 32 | Secondary group A interrupt lines |
| line_b | input | 32 | Secondary group B interrupt lines |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
Two functions can act on the primary word in the same cycle: the summary flag and a mirror bit, when a mirrored line and an unmirrored line of the same group are both active. The bench raises both lines together, then drops them one at a time. Bit 8 must follow only the unmirrored line and the mirror bit only the mirrored one. A mask write can also land in the cycle where a line changes. That case is judged by sampling the status and irq_out before and after the clock edge that commits the mask.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants for the three-bank interrupt aggregator.
// Assumes byte addressing with 32-bit registers.
package irq_agg_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int PRI_N   = 8;
    localparam int SEC_N   = 32;
    localparam int MIR_A_N = 5;
    localparam int MIR_B_N = 6;
    localparam int SUM_A_BIT  = 8;
    localparam int SUM_B_BIT  = 9;
    localparam int MIR_A_BASE = 10;
    localparam int MIR_B_BASE = MIR_A_BASE + MIR_A_N;
    localparam int TOP_LAST   = MIR_B_BASE + MIR_B_N - 1;

    localparam logic [ADDR_W-1:0] OFF_STAT_P = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_STAT_A = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT_B = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_SET_A  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_SET_B  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_SET_P  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_CLR_A  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_CLR_B  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CLR_P  = 8'h24;

    // Source line in group A that feeds mirror slot idx
    function automatic int mirror_src_a(input int idx);
        case (idx)
            0: return 7;
            1: return 9;
            2: return 10;
            3: return 18;
            default: return 19;
        endcase
    endfunction

    // Source line in group B that feeds mirror slot idx
    function automatic int mirror_src_b(input int idx);
        case (idx)
            0: return 21;
            1: return 22;
            2: return 23;
            3: return 24;
            4: return 25;
            default: return 30;
        endcase
    endfunction

    // Mask of group A lines that are not mirrored
    function automatic logic [SEC_N-1:0] plain_mask_a();
        logic [SEC_N-1:0] m = '1;
        for (int i = 0; i < MIR_A_N; i++) m[mirror_src_a(i)] = 1'b0;
        return m;
    endfunction

    // Mask of group B lines that are not mirrored
    function automatic logic [SEC_N-1:0] plain_mask_b();
        logic [SEC_N-1:0] m = '1;
        for (int i = 0; i < MIR_B_N; i++) m[mirror_src_b(i)] = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/irq_mask_reg.sv
// Module: one group's enable mask with set-by-one and clear-by-one addresses.
// Assumes at most one bus write per cycle and a synchronous active-low reset.
module irq_mask_reg #(
    parameter int                                  WIDTH   = 32,
    parameter logic [irq_agg_pkg::ADDR_W-1:0]      SET_OFF = '0,
    parameter logic [irq_agg_pkg::ADDR_W-1:0]      CLR_OFF = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr,
    input  logic [irq_agg_pkg::ADDR_W-1:0]    addr,
    input  logic [WIDTH-1:0]                  wdata,
    output logic [WIDTH-1:0]                  mask_q
);
    logic hit_set;
    logic hit_clr;

    // Decode which of this group's mask addresses is written
    always_comb begin
        hit_set = wr && (addr == SET_OFF);
        hit_clr = wr && (addr == CLR_OFF);
    end

    // Update the mask: ones set on the set address, ones clear on the clear address
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (hit_set)
            mask_q <= mask_q | wdata;
        else if (hit_clr)
            mask_q <= mask_q & ~wdata;
    end

    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == SET_OFF) |=> ((mask_q & $past(wdata)) == $past(wdata)));
    a_r3_clr_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == CLR_OFF) |=> ((mask_q & $past(wdata)) == '0));
    a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == SET_OFF || addr == CLR_OFF)) |=>
            ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr || (addr != SET_OFF && addr != CLR_OFF)) |=> $stable(mask_q));
endmodule

// File: rtl/irq_top_word.sv
// Module: builds the primary status word from masked lines of all groups.
// Assumes inputs are already masked; fully combinational.
module irq_top_word
    import irq_agg_pkg::*;
(
    input  logic [PRI_N-1:0]  act_p,
    input  logic [SEC_N-1:0]  act_a,
    input  logic [SEC_N-1:0]  act_b,
    output logic [DATA_W-1:0] word
);
    localparam logic [SEC_N-1:0] PLAIN_A = plain_mask_a();
    localparam logic [SEC_N-1:0] PLAIN_B = plain_mask_b();

    logic [MIR_A_N-1:0] mir_a;
    logic [MIR_B_N-1:0] mir_b;

    // Pick out the mirrored lines of group A
    for (genvar i = 0; i < MIR_A_N; i++) begin : g_mir_a
        assign mir_a[i] = act_a[mirror_src_a(i)];
    end

    // Pick out the mirrored lines of group B
    for (genvar i = 0; i < MIR_B_N; i++) begin : g_mir_b
        assign mir_b[i] = act_b[mirror_src_b(i)];
    end

    // Assemble direct bits, summary flags and mirror bits
    always_comb begin
        word = '0;
        word[PRI_N-1:0]               = act_p;
        word[SUM_A_BIT]               = |(act_a & PLAIN_A);
        word[SUM_B_BIT]               = |(act_b & PLAIN_B);
        word[MIR_A_BASE +: MIR_A_N]   = mir_a;
        word[MIR_B_BASE +: MIR_B_N]   = mir_b;
    end
endmodule

// File: rtl/banked_irq_agg.sv
// Module: three-bank level interrupt aggregator with mirror bits.
// Assumes level-sensitive lines synchronous to clk and a single-cycle bus.
module banked_irq_agg
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        line_p,
    input  logic [31:0]       line_a,
    input  logic [31:0]       line_b,
    output logic              irq_out
);
    logic [PRI_N-1:0]  mask_p;
    logic [SEC_N-1:0]  mask_a;
    logic [SEC_N-1:0]  mask_b;
    logic [PRI_N-1:0]  act_p;
    logic [SEC_N-1:0]  act_a;
    logic [SEC_N-1:0]  act_b;
    logic [DATA_W-1:0] top_word;

    irq_mask_reg #(.WIDTH(PRI_N), .SET_OFF(OFF_SET_P), .CLR_OFF(OFF_CLR_P)) i_mask_p (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata[PRI_N-1:0]), .mask_q(mask_p));
    irq_mask_reg #(.WIDTH(SEC_N), .SET_OFF(OFF_SET_A), .CLR_OFF(OFF_CLR_A)) i_mask_a (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata[SEC_N-1:0]), .mask_q(mask_a));
    irq_mask_reg #(.WIDTH(SEC_N), .SET_OFF(OFF_SET_B), .CLR_OFF(OFF_CLR_B)) i_mask_b (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata[SEC_N-1:0]), .mask_q(mask_b));

    // Gate each line with its enable
    always_comb begin
        act_p = line_p & mask_p;
        act_a = line_a & mask_a;
        act_b = line_b & mask_b;
    end

    irq_top_word i_top_word (.act_p(act_p), .act_a(act_a), .act_b(act_b), .word(top_word));

    // Raise the request when any primary status bit is set
    assign irq_out = |top_word[TOP_LAST:0];

    // Read multiplexer over the nine register addresses
    always_comb begin
        case (bus_addr)
            OFF_STAT_P:             bus_rdata = top_word;
            OFF_STAT_A:             bus_rdata = act_a;
            OFF_STAT_B:             bus_rdata = act_b;
            OFF_SET_P, OFF_CLR_P:   bus_rdata = {{(DATA_W-PRI_N){1'b0}}, mask_p};
            OFF_SET_A, OFF_CLR_A:   bus_rdata = mask_a;
            OFF_SET_B, OFF_CLR_B:   bus_rdata = mask_b;
            default:                bus_rdata = '0;
        endcase
    end

    a_r8_irq_any_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(line_p & mask_p) || |(line_a & mask_a) || |(line_b & mask_b)));
    a_r7_top_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        top_word[DATA_W-1:TOP_LAST+1] == '0);
    a_r5_sum_a_needs_plain: assert property (@(posedge clk) disable iff (!rst_n)
        top_word[SUM_A_BIT] |-> ($countones(act_a) > $countones(top_word[MIR_A_BASE +: MIR_A_N])));
endmodule

// File: tb/test_banked_irq_agg.sv
`timescale 1ns/1ps
module test_banked_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  line_p = '0;
    logic [31:0] line_a = '0;
    logic [31:0] line_b = '0;
    logic        irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench model of the masks
    logic [7:0]  m_p = '0;
    logic [31:0] m_a = '0;
    logic [31:0] m_b = '0;

    int mir_a_src [5] = '{7, 9, 10, 18, 19};
    int mir_b_src [6] = '{21, 22, 23, 24, 25, 30};

    always #2.5 clk = ~clk;

    banked_irq_agg i_banked_irq_agg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_p(line_p),
        .line_a(line_a), .line_b(line_b), .irq_out(irq_out));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_top();
        logic [31:0] w = '0;
        logic [31:0] a = line_a & m_a;
        logic [31:0] b = line_b & m_b;
        logic [31:0] pa = a;
        logic [31:0] pb = b;
        w[7:0] = line_p & m_p;
        for (int i = 0; i < 5; i++) begin
            w[10+i] = a[mir_a_src[i]];
            pa[mir_a_src[i]] = 1'b0;
        end
        for (int i = 0; i < 6; i++) begin
            w[15+i] = b[mir_b_src[i]];
            pb[mir_b_src[i]] = 1'b0;
        end
        w[8] = |pa;
        w[9] = |pb;
        return w;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        case (a)
            8'h18: m_p = m_p | d[7:0];
            8'h24: m_p = m_p & ~d[7:0];
            8'h10: m_a = m_a | d;
            8'h1C: m_a = m_a & ~d;
            8'h14: m_b = m_b | d;
            8'h20: m_b = m_b & ~d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        logic [31:0] t = exp_top();
        rd(8'h00, d); check({req, " top"}, d, t);
        rd(8'h04, d); check({req, " statA"}, d, line_a & m_a);
        rd(8'h08, d); check({req, " statB"}, d, line_b & m_b);
        check({req, " irq"}, {31'b0, irq_out}, {31'b0, |t[20:0]});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        line_p = '1; line_a = '1; line_b = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h00, d); check("R1 top after reset", d, 32'h0);
        rd(8'h04, d); check("R1 statA after reset", d, 32'h0);
        rd(8'h10, d); check("R1 maskA after reset", d, 32'h0);
        check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
        line_p = '0; line_a = '0; line_b = '0;
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        wr(8'h10, 32'h0000_00F0);
        wr(8'h10, 32'h0000_0000);
        rd(8'h10, d); check("R2 set/zero keeps", d, 32'h0000_00F0);
        rd(8'h1C, d); check("R2 read at clear addr", d, 32'h0000_00F0);
        wr(8'h1C, 32'h0000_0030);
        rd(8'h10, d); check("R3 clear", d, 32'h0000_00C0);
        wr(8'h14, 32'hA500_0001);
        rd(8'h20, d); check("R2 maskB", d, 32'hA500_0001);
        wr(8'h20, '1);
        wr(8'h1C, '1);
        rd(8'h14, d); check("R3 clear all B", d, 32'h0);
    endtask

    task automatic t_pending();
        wr(8'h18, 32'h0000_0055);
        wr(8'h10, 32'h0000_0003);
        wr(8'h14, 32'h8000_0000);
        line_p = 8'hFF; line_a = 32'h0000_0006; line_b = 32'hC000_0000;
        check_all("R4 pending");
        line_p = 8'h00;
        check_all("R4 pending follows line");
        line_a = '0; line_b = '0;
        check_all("R8 irq falls");
        wr(8'h24, '1); wr(8'h1C, '1); wr(8'h20, '1);
    endtask

    task automatic t_mirrors();
        wr(8'h10, '1); wr(8'h14, '1);
        for (int i = 0; i < 5; i++) begin
            line_a = 32'h1 << mir_a_src[i];
            check_all("R6 mirror A");
        end
        for (int i = 0; i < 6; i++) begin
            line_b = 32'h1 << mir_b_src[i];
            check_all("R6 mirror B");
        end
        line_a = '0; line_b = '0;
        wr(8'h1C, 32'h1 << 9);
        line_a = 32'h1 << 9;
        check_all("R6 mirror masked by own group");
        line_a = '0;
        wr(8'h1C, '1); wr(8'h20, '1);
    endtask

    task automatic t_summary_overlap();
        logic [31:0] d;
        wr(8'h10, '1); wr(8'h14, '1);
        line_a = (32'h1 << 7) | (32'h1 << 3);
        line_b = (32'h1 << 30) | (32'h1 << 29);
        rd(8'h00, d); check("R5 both flags plus mirrors", d, 32'h0010_0701 >> 0 & 32'h0 | exp_top());
        check("R5 bit8 with mirror", {31'b0, d[8]}, 32'h1);
        check("R6 mirror slot0 set", {31'b0, d[10]}, 32'h1);
        line_a = 32'h1 << 7; line_b = 32'h1 << 30;
        rd(8'h00, d);
        check("R5 mirror alone leaves flags clear", d, (32'h1 << 10) | (32'h1 << 20));
        line_a = 32'h1 << 3; line_b = 32'h0;
        rd(8'h00, d); check("R5 plain A only", d, 32'h0000_0100);
        line_a = '0; line_b = 32'h1 << 2;
        rd(8'h00, d); check("R5 plain B only", d, 32'h0000_0200);
        line_b = '0;
        wr(8'h1C, '1); wr(8'h20, '1);
    endtask

    task automatic t_primary_protect();
        logic [31:0] d;
        wr(8'h10, '1);
        line_a = 32'h1 << 7;
        wr(8'h24, 32'hFFFF_FF00);
        rd(8'h00, d); check("R7 clear high bits no effect", d, 32'h0000_0400);
        wr(8'h18, 32'hFFFF_FF00);
        rd(8'h18, d); check("R7 primary mask high bits", d, 32'h0);
        line_a = '1; line_b = '1; wr(8'h14, '1);
        rd(8'h00, d); check("R7 top bits 31:21 zero", d & 32'hFFE0_0000, 32'h0);
        line_a = '0; line_b = '0;
        wr(8'h1C, '1); wr(8'h20, '1);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h18, 32'h0000_0001);
        line_p = 8'h01;
        wr(8'h0C, '1);
        wr(8'h28, '1);
        rd(8'h0C, d); check("R9 unmapped read 0x0C", d, 32'h0);
        rd(8'h28, d); check("R9 unmapped read 0x28", d, 32'h0);
        rd(8'h10, d); check("R9 maskA untouched", d, 32'h0);
        rd(8'h18, d); check("R9 maskP untouched", d, 32'h1);
        line_p = '0;
        wr(8'h24, '1);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        @(negedge clk);
        line_p = 8'h10; bus_addr = 8'h18; bus_wr = 1'b1; bus_wdata = 32'h10;
        #1;
        check("R8 before mask edge", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; m_p = 8'h10;
        check("R8 after mask edge", {31'b0, irq_out}, 32'h1);
        rd(8'h00, d); check("R4 after mask edge", d, 32'h10);
        line_p = '0;
        #1;
        check("R8 falls with line", {31'b0, irq_out}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_set_clear();
        t_pending();
        t_mirrors();
        t_summary_overlap();
        t_primary_protect();
        t_unmapped();
        t_same_cycle();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule